// File: doc/BRIEF.md
# Single-Digit Hex/Decimal Multiplier

This block multiplies two 4-bit digits in one combinational pass and presents the result in one of two formats. With the decimal select high, both operands are taken as BCD digits. The product, at most 81, is returned as two packed BCD digits. With the select low, the operands are plain unsigned nibbles, and the product, at most 225, is returned as an 8-bit binary value. One shared datapath serves both modes. Only a binary-to-two-digit stage sits between the shared product and the decimal output.

Each operand is split at 8 into a magnitude bit and a 3-bit remainder. Most operand pairs then need only a 3x3 product and shifted copies of a remainder. The 64-weight term is used only when both operands are 8 or above, and in decimal mode that is just the four pairs built from 8 and 9. In decimal mode the block flags any operand that is not a BCD digit. The block holds no state and has no clock. It is meant to be placed many times inside a larger multi-digit multiplier that does its own accumulation.

Top module: `hexdec_digit_mul`

## Requirements
- R1: With `dec_sel` low, `product` equals the unsigned 8-bit binary product of `op_a` and `op_b` for all 256 operand pairs.
- R2: With `dec_sel` high and both operands in 0..9, `product[7:4]` holds the tens digit and `product[3:0]` the units digit, and tens*10+units equals `op_a*op_b`.
- R3: With `dec_sel` high and both operands valid, both output nibbles are at most 9 and the tens nibble is at most 8.
- R4: With `dec_sel` high, `bcd_err` is 1 exactly when `op_a` > 9 or `op_b` > 9.
- R5: With `dec_sel` low, `bcd_err` is 0 for every operand pair.
- R6: A zero operand gives `product` = 8'h00 in both modes.
- R7: The pairs where both operands are large give exact results: 8x8=8'h64, 8x9=9x8=8'h72 and 9x9=8'h81 in decimal mode, and 15x15=8'hE1 in binary mode.
- R8: A unit operand returns the other operand unchanged in both modes, as the binary value in binary mode and as BCD 8'h0d for digit d in decimal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First digit operand |
| op_b | input | 4 | Second digit operand |
| dec_sel | input | 1 | 1 selects decimal (two BCD digits), 0 selects binary output |
| product | output | 8 | Product: BCD tens in [7:4] and units in [3:0], or 8-bit binary |
| bcd_err | output | 1 | Decimal mode only: an operand exceeds 9 |

## Verification
The hardest case to reach is the path where both operands are large and the 64-weight term adds to both cross terms. It shows up in only four valid decimal pairs, and a directed task drives each of them together with the binary extremes. The other hard area is the decimal conversion near each multiple of ten. Full sweeps of all operand pairs in both modes reach every tens boundary the product can hit. The results are compared against a reference computed with integer division.

// File: rtl/hexdec_digit_mul.sv
module hexdec_digit_mul (
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  input  logic       dec_sel,
  output logic [7:0] product,
  output logic       bcd_err
);
  logic       a_big, b_big;
  logic [2:0] a_rem, b_rem;
  logic [5:0] rem_pp;
  logic [5:0] a_cross, b_cross;
  logic [7:0] big_term;
  logic [7:0] bin;
  logic [3:0] tens, units;

  assign a_big = op_a[3];
  assign b_big = op_b[3];
  assign a_rem = op_a[2:0];
  assign b_rem = op_b[2:0];

  assign rem_pp   = {3'b000, a_rem} * {3'b000, b_rem};
  assign a_cross  = a_big ? {b_rem, 3'b000} : 6'd0;
  assign b_cross  = b_big ? {a_rem, 3'b000} : 6'd0;
  assign big_term = (a_big & b_big) ? 8'd64 : 8'd0;

  assign bin = big_term + {2'b00, a_cross} + {2'b00, b_cross} + {2'b00, rem_pp};

  always_comb begin
    tens = 4'd0;
    for (int k = 1; k < 10; k++)
      if (bin >= 8'(k * 10)) tens = 4'(k);
    units = 4'(bin - {1'b0, tens, 3'b000} - {3'b000, tens, 1'b0});
  end

  assign product = dec_sel ? {tens, units} : bin;
  assign bcd_err = dec_sel & ((op_a > 4'd9) | (op_b > 4'd9));
endmodule

module hexdec_digit_mul_chk (
  input logic [3:0] op_a,
  input logic [3:0] op_b,
  input logic       dec_sel,
  input logic [7:0] product,
  input logic       bcd_err
);
  logic valid;
  assign valid = (op_a <= 4'd9) && (op_b <= 4'd9);

  always_comb begin
    // R1
    hex_prod_chk: assert (dec_sel || product == ({4'd0, op_a} * {4'd0, op_b}));
    // R2
    dec_value_chk: assert (!dec_sel || !valid ||
      ({4'd0, product[7:4]} * 8'd10 + {4'd0, product[3:0]}) == ({4'd0, op_a} * {4'd0, op_b}));
    // R3
    dec_digit_chk: assert (!dec_sel || !valid || (product[3:0] <= 4'd9 && product[7:4] <= 4'd8));
    // R4
    bcd_flag_chk: assert (!dec_sel || (bcd_err == !valid));
    // R5
    hex_noflag_chk: assert (dec_sel || !bcd_err);
    // R6
    zero_chk: assert (!(op_a == 4'd0 || op_b == 4'd0) || (dec_sel && !valid) || product == 8'h00);
  end
endmodule

bind hexdec_digit_mul hexdec_digit_mul_chk u_chk (
  .op_a(op_a), .op_b(op_b), .dec_sel(dec_sel), .product(product), .bcd_err(bcd_err)
);

// File: tb/tb_hexdec_digit_mul.sv
module tb_hexdec_digit_mul;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] op_a = 4'd0;
  logic [3:0] op_b = 4'd0;
  logic       dec_sel = 1'b0;
  logic [7:0] product;
  logic       bcd_err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hexdec_digit_mul dut (
    .op_a(op_a), .op_b(op_b), .dec_sel(dec_sel), .product(product), .bcd_err(bcd_err)
  );

  function automatic logic [7:0] ref_hex(input int a, input int b);
    return 8'(a * b);
  endfunction

  function automatic logic [7:0] ref_dec(input int a, input int b);
    int p;
    p = a * b;
    return {4'(p / 10), 4'(p % 10)};
  endfunction

  task automatic apply(input int a, input int b, input logic d);
    @(posedge clk);
    op_a = 4'(a); op_b = 4'(b); dec_sel = d;
    @(negedge clk);
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d dec=%0b actual=%h expected=%h", req, op_a, op_b, dec_sel, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk8("R6", product, 8'h00);
    chk8("R5", {7'd0, bcd_err}, 8'h00);
  endtask

  task automatic t_hex_sweep;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(a, b, 1'b0);
        chk8("R1", product, ref_hex(a, b));
        chk8("R5", {7'd0, bcd_err}, 8'h00);
      end
  endtask

  task automatic t_dec_sweep;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(a, b, 1'b1);
        chk8("R4", {7'd0, bcd_err}, {7'd0, (a > 9 || b > 9)});
        if (a <= 9 && b <= 9) begin
          chk8("R2", product, ref_dec(a, b));
          chk8("R3", {7'd0, (product[3:0] <= 4'd9 && product[7:4] <= 4'd8)}, 8'h01);
        end
      end
  endtask

  task automatic t_big_pairs;
    apply(8, 8, 1'b1); chk8("R7", product, 8'h64);
    apply(8, 9, 1'b1); chk8("R7", product, 8'h72);
    apply(9, 8, 1'b1); chk8("R7", product, 8'h72);
    apply(9, 9, 1'b1); chk8("R7", product, 8'h81);
    apply(15, 15, 1'b0); chk8("R7", product, 8'hE1);
    apply(8, 15, 1'b0); chk8("R7", product, 8'h78);
  endtask

  task automatic t_zero;
    for (int v = 0; v < 10; v++) begin
      apply(0, v, 1'b1); chk8("R6", product, 8'h00);
      apply(v, 0, 1'b0); chk8("R6", product, 8'h00);
    end
    apply(0, 15, 1'b0); chk8("R6", product, 8'h00);
  endtask

  task automatic t_unit;
    for (int v = 0; v < 16; v++) begin
      apply(1, v, 1'b0); chk8("R8", product, 8'(v));
      if (v <= 9) begin
        apply(v, 1, 1'b1); chk8("R8", product, {4'h0, 4'(v)});
      end
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_hex_sweep();
    t_dec_sweep();
    t_big_pairs();
    t_zero();
    t_unit();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule